// File: doc/BRIEF.md
# Banked Slot Bridge for a Video Controller

This block sits between a host CPU expansion slot and a video controller. The slot drives two chip selects. One opens a 256-byte register window. The other opens a 1 MB data window.

In the register window, the top word returns a fixed board identifier. Low word offsets reach a small bank of control registers. These registers hold the screen mode, palette settings and drawing parameters, and their contents are exposed to the rest of the controller. Any other word offset in the window reads as zero and ignores writes.

The data window maps straight onto an external 16-bit video SRAM that is larger than the window. Control register 0 acts as a bank select. It supplies the upper SRAM address bits, and the low 19 word-address bits come from the slot. Each data access is handed to an SRAM arbiter through a request/grant pair. The data moves in the grant cycle, and the slot sees an acknowledge one cycle later.

Top module: `vsb_bridge`

## Requirements
- R1: While reset is held and right after it: `ack` is 0, `sram_req` is 0, `bank` is 0 and every control register reads 0 on `ctl_regs`.
- R2: A register-window write to word offset `addr[7:1]` below NUM_REGS (default 8) updates only the byte lanes whose strobe is high (`ube` for bits 15:8, `lbe` for bits 7:0). Register n appears on `ctl_regs[16n+15:16n]`. A read of that offset returns the whole stored word, whatever the strobes.
- R3: A read of the top register word (byte offsets 0xFE and 0xFF, word offset 0x7F) returns BOARD_ID (default 0xB0A7). Writes there change no register.
- R4: Word offsets from NUM_REGS up to 0x7E read as zero, and writes to them change no register.
- R5: A register access taken while idle gives `ack` high for exactly one cycle, in the cycle after the chip select is sampled. The read data is valid in that cycle. No further access starts until both chip selects have been low at a clock edge.
- R6: A data-window access raises `sram_req` in the cycle after the select is sampled. `sram_req` holds, with a stable `sram_addr`, until the cycle in which `sram_gnt` is high. `ack` is high for one cycle in the cycle after that grant.
- R7: The SRAM word address is {bank, addr[19:1]}. `bank` is bits [BANK_W-1:0] of control register 0 (BANK_W default 1), sampled when the access starts. `bank` changes only through a write to register 0.
- R8: During a data access, `sram_we` follows `wr`, `sram_be` is {ube, lbe} and `sram_wdata` is the slot write data. A read returns the `sram_rdata` present in the grant cycle.
- R9: When both chip selects rise together, the register access is served and no SRAM request is raised for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_cs | input | 1 | Register window select |
| dat_cs | input | 1 | Data window select |
| addr | input | 19 | Word address within the window (byte address bits 19:1) |
| wr | input | 1 | 1 = write, 0 = read |
| ube | input | 1 | Upper byte strobe (bits 15:8) |
| lbe | input | 1 | Lower byte strobe (bits 7:0) |
| wdata | input | 16 | Write data from the slot |
| rdata | output | 16 | Read data to the slot, valid while ack is high |
| ack | output | 1 | One-cycle access acknowledge |
| sram_req | output | 1 | Request to the SRAM arbiter |
| sram_gnt | input | 1 | Grant; the SRAM transfer happens in this cycle |
| sram_addr | output | 20 | SRAM word address |
| sram_we | output | 1 | SRAM write enable |
| sram_be | output | 2 | SRAM byte enables {upper, lower} |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, sampled in the grant cycle |
| ctl_regs | output | 128 | Flattened control registers, register n at bits 16n+15:16n |
| bank | output | 1 | Current bank select |

## Verification
The in-line properties check the handshake every cycle. They cover the single-cycle acknowledge, the request held with a stable address until grant, the acknowledge after a grant, and register priority when both selects collide. They also check that the bank and the registers stay unchanged without a write, and that the ID and unmapped offsets return their fixed values.

Other behaviours need the bench's scenarios. These include byte-lane merging in both the registers and the SRAM, the correct splicing of the bank bits into the SRAM address, and isolation between the two banks at one window offset. They also include read data matching earlier writes across random grant delays.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    WSEL_NONE = 2'd0,
    WSEL_REG  = 2'd1,
    WSEL_ID   = 2'd2
  } win_sel_t;

endpackage

// File: rtl/vsb_decode.sv
module vsb_decode
  import vsb_pkg::*;
#(
  parameter  int REG_AW   = 8,
  parameter  int NUM_REGS = 8,
  localparam int WORD_W   = REG_AW - 1,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [WORD_W-1:0] word,
  output win_sel_t          sel,
  output logic [IDX_W-1:0]  idx
);

  // The topmost word of the window carries the identifier; low words map to
  // implemented registers; everything in between is a hole.
  always_comb begin
    idx = word[IDX_W-1:0];
    if (&word) begin
      sel = WSEL_ID;
    end else if (int'(word) < NUM_REGS) begin
      sel = WSEL_REG;
    end else begin
      sel = WSEL_NONE;
    end
  end

endmodule

// File: rtl/vsb_regfile.sv
module vsb_regfile #(
  parameter  int DW       = 16,
  parameter  int NUM_REGS = 8,
  parameter  int BANK_W   = 1,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int NB       = DW / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [NB-1:0]          be,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] ctl_flat,
  output logic [BANK_W-1:0]      bank
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic          hit;
    logic [DW-1:0] reg_d;
    logic [DW-1:0] reg_q;

    assign hit = wr_en && (idx == IDX_W'(r));

    always_comb begin
      reg_d = reg_q;
      for (int b = 0; b < NB; b++) begin
        if (be[b]) begin
          reg_d[b*8 +: 8] = wdata[b*8 +: 8];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q <= '0;
      end else if (hit) begin
        reg_q <= reg_d;
      end
    end

    assign ctl_flat[r*DW +: DW] = reg_q;
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (idx == IDX_W'(r)) begin
        rdata = ctl_flat[r*DW +: DW];
      end
    end
  end

  assign bank = ctl_flat[BANK_W-1:0];

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && idx == '0) |=> $stable(bank));

  // R2
  reg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_flat));

endmodule

// File: rtl/vsb_seq.sv
module vsb_seq
  import vsb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reg_cs,
  input  logic dat_cs,
  input  logic sram_gnt,
  output logic reg_take,
  output logic dat_take,
  output logic gnt_take,
  output logic sram_req,
  output logic ack
);

  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (reg_cs) begin
          state_d = ST_ACK;
        end else if (dat_cs) begin
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (sram_gnt) begin
          state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        state_d = (reg_cs || dat_cs) ? ST_HOLD : ST_IDLE;
      end
      ST_HOLD: begin
        if (!reg_cs && !dat_cs) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign reg_take = (state_q == ST_IDLE) && reg_cs;
  assign dat_take = (state_q == ST_IDLE) && !reg_cs && dat_cs;
  assign gnt_take = (state_q == ST_REQ) && sram_gnt;
  assign sram_req = (state_q == ST_REQ);
  assign ack      = (state_q == ST_ACK);

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R5
  reg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_take |=> ack);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_req && !sram_gnt |=> sram_req);

  // R6
  gnt_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_req && sram_gnt |=> ack && !sram_req);

endmodule

// File: rtl/vsb_sram_port.sv
module vsb_sram_port #(
  parameter  int DW     = 16,
  parameter  int WIN_AW = 20,
  parameter  int BANK_W = 1,
  localparam int WA_W   = WIN_AW - 1,
  localparam int SA_W   = BANK_W + WA_W,
  localparam int NB     = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              req,
  input  logic              gnt,
  input  logic [WA_W-1:0]   word_addr,
  input  logic [BANK_W-1:0] bank,
  input  logic              we,
  input  logic [NB-1:0]     be,
  input  logic [DW-1:0]     wdata,
  output logic [SA_W-1:0]   sram_addr,
  output logic              sram_we,
  output logic [NB-1:0]     sram_be,
  output logic [DW-1:0]     sram_wdata
);

  logic [SA_W-1:0] addr_q, addr_d;
  logic            we_q,   we_d;
  logic [NB-1:0]   be_q,   be_d;
  logic [DW-1:0]   dat_q,  dat_d;

  always_comb begin
    addr_d = {bank, word_addr};
    we_d   = we;
    be_d   = be;
    dat_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      we_q   <= 1'b0;
      be_q   <= '0;
      dat_q  <= '0;
    end else if (take) begin
      addr_q <= addr_d;
      we_q   <= we_d;
      be_q   <= be_d;
      dat_q  <= dat_d;
    end
  end

  assign sram_addr  = addr_q;
  assign sram_we    = we_q;
  assign sram_be    = be_q;
  assign sram_wdata = dat_q;

  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !gnt |=> $stable(sram_addr) && $stable(sram_we));

endmodule

// File: rtl/vsb_bridge.sv
module vsb_bridge
  import vsb_pkg::*;
#(
  parameter  int            DW       = 16,
  parameter  int            WIN_AW   = 20,
  parameter  int            REG_AW   = 8,
  parameter  int            NUM_REGS = 8,
  parameter  int            BANK_W   = 1,
  parameter  logic [15:0]   BOARD_ID = 16'hB0A7,
  localparam int            SA_W     = BANK_W + WIN_AW - 1,
  localparam int            IDX_W    = $clog2(NUM_REGS),
  localparam int            NB       = DW / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_cs,
  input  logic                   dat_cs,
  input  logic [WIN_AW-1:1]      addr,
  input  logic                   wr,
  input  logic                   ube,
  input  logic                   lbe,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic                   ack,
  output logic                   sram_req,
  input  logic                   sram_gnt,
  output logic [SA_W-1:0]        sram_addr,
  output logic                   sram_we,
  output logic [NB-1:0]          sram_be,
  output logic [DW-1:0]          sram_wdata,
  input  logic [DW-1:0]          sram_rdata,
  output logic [NUM_REGS*DW-1:0] ctl_regs,
  output logic [BANK_W-1:0]      bank
);

  // Reset: asserted at once, released on the second clock edge.
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_i_n = rst_pipe[1];

  logic             reg_take, dat_take, gnt_take;
  win_sel_t         sel;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    rf_rdata;
  logic             rf_wr;
  logic [NB-1:0]    be;

  assign be    = NB'({ube, lbe});
  assign rf_wr = reg_take && wr && (sel == WSEL_REG);

  vsb_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .reg_cs   (reg_cs),
    .dat_cs   (dat_cs),
    .sram_gnt (sram_gnt),
    .reg_take (reg_take),
    .dat_take (dat_take),
    .gnt_take (gnt_take),
    .sram_req (sram_req),
    .ack      (ack)
  );

  vsb_decode #(.REG_AW(REG_AW), .NUM_REGS(NUM_REGS)) i_decode (
    .word (addr[REG_AW-1:1]),
    .sel  (sel),
    .idx  (idx)
  );

  vsb_regfile #(.DW(DW), .NUM_REGS(NUM_REGS), .BANK_W(BANK_W)) i_regfile (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (rf_wr),
    .idx      (idx),
    .be       (be),
    .wdata    (wdata),
    .rdata    (rf_rdata),
    .ctl_flat (ctl_regs),
    .bank     (bank)
  );

  vsb_sram_port #(.DW(DW), .WIN_AW(WIN_AW), .BANK_W(BANK_W)) i_sram_port (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .take       (dat_take),
    .req        (sram_req),
    .gnt        (sram_gnt),
    .word_addr  (addr),
    .bank       (bank),
    .we         (wr),
    .be         (be),
    .wdata      (wdata),
    .sram_addr  (sram_addr),
    .sram_we    (sram_we),
    .sram_be    (sram_be),
    .sram_wdata (sram_wdata)
  );

  // Read data register, loaded at register accept or at SRAM grant.
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rdata_ld;

  assign rdata_ld = reg_take || gnt_take;

  always_comb begin
    rdata_d = rdata_q;
    if (reg_take) begin
      unique case (sel)
        WSEL_ID:  rdata_d = BOARD_ID[DW-1:0];
        WSEL_REG: rdata_d = rf_rdata;
        default:  rdata_d = '0;
      endcase
    end else if (gnt_take) begin
      rdata_d = sram_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q <= '0;
    end else if (rdata_ld) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // R3
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    reg_take && sel == WSEL_ID |=> ack && rdata == BOARD_ID[DW-1:0]);

  // R4
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    reg_take && sel == WSEL_NONE |=> ack && rdata == '0);

  // R9
  reg_prio_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    reg_take && dat_cs |=> !sram_req);

  // R8
  gnt_data_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    gnt_take |=> rdata == $past(sram_rdata));

endmodule

// File: tb/test_vsb_bridge.sv
`timescale 1ns/1ps
module test_vsb_bridge;

  localparam logic [15:0] ID = 16'hB0A7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_cs = 1'b0, dat_cs = 1'b0, wr = 1'b0, ube = 1'b0, lbe = 1'b0;
  logic [19:1]  addr = '0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rdata;
  logic         ack, sram_req, sram_we;
  logic         sram_gnt = 1'b0;
  logic [19:0]  sram_addr;
  logic [1:0]   sram_be;
  logic [15:0]  sram_wdata;
  logic [15:0]  sram_rdata = '0;
  logic [127:0] ctl_regs;
  logic [0:0]   bank;

  always #2.5 clk = ~clk;

  vsb_bridge i_vsb_bridge (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .dat_cs(dat_cs), .addr(addr),
    .wr(wr), .ube(ube), .lbe(lbe), .wdata(wdata), .rdata(rdata), .ack(ack),
    .sram_req(sram_req), .sram_gnt(sram_gnt), .sram_addr(sram_addr),
    .sram_we(sram_we), .sram_be(sram_be), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .ctl_regs(ctl_regs), .bank(bank)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [15:0] exp_reg [8];
  logic [15:0] sram_mem [logic [19:0]];
  logic [15:0] exp_mem  [logic [19:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [1:0] be,
                                        input logic [15:0] d);
    logic [15:0] r = old;
    if (be[1]) r[15:8] = d[15:8];
    if (be[0]) r[7:0]  = d[7:0];
    return r;
  endfunction

  function automatic logic [15:0] reg_expect(input logic [6:0] w);
    if (w == 7'h7F) return ID;
    if (w < 7'd8)   return exp_reg[w[2:0]];
    return 16'h0000;
  endfunction

  function automatic logic [15:0] mem_get(input logic [19:0] a, input bit from_exp);
    if (from_exp) return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
    return sram_mem.exists(a) ? sram_mem[a] : 16'h0000;
  endfunction

  task automatic check_regs();
    for (int r = 0; r < 8; r++) chk("R2 ctl_regs", 32'(ctl_regs[r*16 +: 16]), 32'(exp_reg[r]));
    chk("R7 bank", 32'(bank), 32'(exp_reg[0][0]));
  endtask

  task automatic reg_op(input bit w, input logic [6:0] word, input logic [1:0] be,
                        input logic [15:0] d);
    logic [15:0] e;
    @(negedge clk);
    reg_cs = 1'b1; wr = w; addr = {12'h000, word}; ube = be[1]; lbe = be[0]; wdata = d;
    e = reg_expect(word);
    if (w && word < 7'd8) exp_reg[word[2:0]] = merge(exp_reg[word[2:0]], be, d);
    @(negedge clk);
    chk("R5 ack after register access", 32'(ack), 1);
    if (!w) begin
      if (word == 7'h7F)     chk("R3 id read", 32'(rdata), 32'(e));
      else if (word >= 7'd8) chk("R4 hole read", 32'(rdata), 32'(e));
      else                   chk("R2 register read", 32'(rdata), 32'(e));
    end
    @(negedge clk);
    chk("R5 ack single pulse", 32'(ack), 0);
    reg_cs = 1'b0; wr = 1'b0;
    @(negedge clk);
    if (w) check_regs();
  endtask

  task automatic dat_op(input bit w, input logic [19:1] a, input logic [1:0] be,
                        input logic [15:0] d, input int dly);
    logic [19:0] ea;
    logic [15:0] e;
    @(negedge clk);
    dat_cs = 1'b1; wr = w; addr = a; ube = be[1]; lbe = be[0]; wdata = d;
    ea = {exp_reg[0][0], a};
    e  = mem_get(ea, 1'b1);
    @(negedge clk);
    chk("R6 request raised", 32'(sram_req), 1);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R6 request held", 32'(sram_req), 1);
      chk("R6 no early ack", 32'(ack), 0);
    end
    chk("R7 sram address", 32'(sram_addr), 32'(ea));
    chk("R8 sram write enable", 32'(sram_we), 32'(w));
    if (w) begin
      chk("R8 sram byte enables", 32'(sram_be), 32'(be));
      chk("R8 sram write data", 32'(sram_wdata), 32'(d));
      sram_mem[sram_addr] = merge(mem_get(sram_addr, 1'b0), sram_be, sram_wdata);
      exp_mem[ea] = merge(e, be, d);
    end
    sram_rdata = mem_get(sram_addr, 1'b0);
    sram_gnt = 1'b1;
    @(negedge clk);
    sram_gnt = 1'b0; sram_rdata = 16'h0000;
    chk("R6 ack after grant", 32'(ack), 1);
    chk("R6 request dropped", 32'(sram_req), 0);
    if (!w) chk("R8 sram read data", 32'(rdata), 32'(e));
    @(negedge clk);
    chk("R6 ack single pulse", 32'(ack), 0);
    dat_cs = 1'b0; wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 8; r++) exp_reg[r] = 16'h0000;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", 32'(ack), 0);
    chk("R1 req in reset", 32'(sram_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ack after reset", 32'(ack), 0);
    chk("R1 req after reset", 32'(sram_req), 0);
    chk("R1 bank after reset", 32'(bank), 0);
    chk("R1 registers after reset", 32'(ctl_regs == '0), 1);

    // R2 full and partial writes
    for (int r = 0; r < 8; r++) reg_op(1'b1, 7'(r), 2'b11, 16'h1100 + 16'(r * 16'h0101));
    for (int r = 0; r < 8; r++) reg_op(1'b0, 7'(r), 2'b11, 16'h0);
    reg_op(1'b1, 7'd3, 2'b10, 16'hAB55);
    reg_op(1'b1, 7'd4, 2'b01, 16'h66CD);
    reg_op(1'b0, 7'd3, 2'b00, 16'h0);
    reg_op(1'b0, 7'd4, 2'b00, 16'h0);

    // R3 ID read and ignored ID write
    reg_op(1'b0, 7'h7F, 2'b11, 16'h0);
    reg_op(1'b1, 7'h7F, 2'b11, 16'h1234);
    reg_op(1'b0, 7'h7F, 2'b01, 16'h0);

    // R4 holes
    reg_op(1'b1, 7'h10, 2'b11, 16'hFFFF);
    reg_op(1'b0, 7'h10, 2'b11, 16'h0);
    reg_op(1'b1, 7'h7E, 2'b11, 16'hFFFF);
    reg_op(1'b0, 7'h7E, 2'b11, 16'h0);

    // R7 bank isolation at the same window offset
    reg_op(1'b1, 7'd0, 2'b11, 16'h0000);
    dat_op(1'b1, 19'h00040, 2'b11, 16'hAAAA, 0);
    reg_op(1'b1, 7'd0, 2'b01, 16'h0001);
    dat_op(1'b1, 19'h00040, 2'b11, 16'h5555, 2);
    dat_op(1'b0, 19'h00040, 2'b11, 16'h0, 1);
    reg_op(1'b1, 7'd0, 2'b01, 16'h0000);
    dat_op(1'b0, 19'h00040, 2'b11, 16'h0, 3);

    // R8 byte writes into SRAM
    dat_op(1'b1, 19'h7FFFF, 2'b10, 16'hC3FF, 0);
    dat_op(1'b1, 19'h7FFFF, 2'b01, 16'hFF3C, 1);
    dat_op(1'b0, 19'h7FFFF, 2'b11, 16'h0, 0);

    // R9 both selects at once
    @(negedge clk);
    reg_cs = 1'b1; dat_cs = 1'b1; wr = 1'b0; addr = 19'h00002;
    @(negedge clk);
    chk("R9 register served", 32'(ack), 1);
    chk("R9 register data", 32'(rdata), 32'(exp_reg[2]));
    chk("R9 no sram request", 32'(sram_req), 0);
    @(negedge clk);
    chk("R9 no sram request later", 32'(sram_req), 0);
    chk("R5 no second ack", 32'(ack), 0);
    reg_cs = 1'b0; dat_cs = 1'b0;
    @(negedge clk);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int k = int'($urandom % 6);
      if (k < 2) begin
        int sel = int'($urandom % 10);
        logic [6:0] w;
        if (sel < 8)       w = 7'(sel);
        else if (sel == 8) w = 7'h7F;
        else               w = 7'(8 + ($urandom % 119));
        reg_op(k == 0, w, 2'($urandom), 16'($urandom));
      end else begin
        logic [19:1] a = (($urandom % 2) != 0) ? 19'h7FFF8 : 19'h00000;
        a[3:1] = 3'($urandom);
        dat_op(k < 4, a, 2'($urandom), 16'($urandom), int'($urandom % 4));
      end
    end

    finish_up();
  end

endmodule